// File: doc/BRIEF.md
# DMA Page Translation Unit

This unit turns device-side DMA addresses into system physical addresses, one 4 KiB page at a time. Software sets up a translation window, given as a base and a mask, and points the unit at a page directory held in system memory. Each request is first reduced to its page by clearing the low 12 address bits. If translation is enabled and the page falls inside the window, the unit reads one 64-bit directory entry through a memory read port and builds the physical page address from that entry. Every other page takes a fixed bypass mapping and needs no memory access.

Only one translation can be in flight at a time. While a directory read is pending, `req_busy` stays high and new requests are not accepted. A directory entry whose valid bit is clear produces a fault response that grants no access. The configuration registers are written and read through a small port that handles both 32-bit and 64-bit accesses.

Top module: `iommu_xlate`

## Requirements
- R1: After reset, all five configuration registers read zero, so translation is disabled. `req_busy`, `rsp_valid` and `mem_req_valid` are low.
- R2: A 64-bit write (`cfg_wide`=1) replaces the whole register. A 32-bit write changes only one half, using `cfg_wdata[31:0]`: the upper half when `cfg_addr[2]`=1, otherwise the lower half. A 32-bit read returns the selected half in `cfg_rdata[31:0]`, with the upper 32 bits zero.
- R3: Register offsets are counted from parameter `REG_BASE` (default 0x20300). The window base is at +0x00, the window mask at +0x08, a spare purge register at +0x10, a spare config register at +0x18 and the directory base at +0x20. Any other 8-byte slot ignores writes and reads as zero.
- R4: When bit 0 of the window base register is 0, every request bypasses the directory. The response appears in the cycle after the request is accepted, and no memory read is issued.
- R5: A page is translated only when (page & mask) equals the window base register with bit 0 cleared. Any other page bypasses the directory.
- R6: For a translated page, `mem_req_valid` is high for exactly one cycle, in the cycle after acceptance. `mem_req_addr` is the directory base plus (address >> 12) * 8.
- R7: If bit 63 of the returned entry is 1, the response gives `rsp_paddr` equal to the entry with bit 63 and bits 11:0 cleared, `rsp_fault`=0 and `rsp_perm`=2'b11 (bit 1 write, bit 0 read). The response comes one cycle after `mem_rsp_valid`.
- R8: If bit 63 of the entry is 0, the response has `rsp_fault`=1 and `rsp_perm`=2'b00.
- R9: A bypassed page above 0xFFFF_FFFF is passed through unchanged. A bypassed page at or below that limit has parameter `LOW_OFFSET` (default 0) added to it. Bypass responses have `rsp_perm`=2'b11. Every response reports the page-aligned request address on `rsp_iova` and 0xfff on `rsp_page_mask`.
- R10: `req_busy` is high from the cycle after a translated request is accepted until its response. A request presented while busy is not accepted and produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | CFG_AW | Register byte address |
| cfg_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| cfg_wdata | input | 64 | Register write data |
| cfg_rdata | output | 64 | Register read data (combinational, follows cfg_addr) |
| req_valid | input | 1 | Translation request |
| req_addr | input | 64 | Device-side address |
| req_busy | output | 1 | Request not accepted while high |
| mem_req_valid | output | 1 | Directory read request |
| mem_req_addr | output | 64 | Directory entry address |
| mem_rsp_valid | input | 1 | Directory entry returned |
| mem_rsp_data | input | 64 | Directory entry, little-endian 64-bit word |
| rsp_valid | output | 1 | Translation result pulse |
| rsp_iova | output | 64 | Page-aligned request address |
| rsp_paddr | output | 64 | Physical page address |
| rsp_page_mask | output | 12 | Page offset mask, always 0xfff |
| rsp_fault | output | 1 | Entry was invalid |
| rsp_perm | output | 2 | Granted access {write, read} |

## Verification
The assertions assume that the memory side raises `mem_rsp_valid` for exactly one cycle per directory read. They also assume it does so no earlier than the cycle after `mem_req_valid`, and never when no read is outstanding. The bench's memory model meets this by answering every captured read a fixed two cycles later with a single-cycle pulse. Register writes in the bench are done only while the unit is idle, so a window change never overlaps a translation that is in flight.

// File: rtl/iommu_xlate.sv
module iommu_xlate #(
  parameter int          CFG_AW     = 18,
  parameter logic [17:0] REG_BASE   = 18'h20300,
  parameter logic [63:0] LOW_OFFSET = 64'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic              cfg_wide,
  input  logic [63:0]       cfg_wdata,
  output logic [63:0]       cfg_rdata,
  input  logic              req_valid,
  input  logic [63:0]       req_addr,
  output logic              req_busy,
  output logic              mem_req_valid,
  output logic [63:0]       mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [63:0]       mem_rsp_data,
  output logic              rsp_valid,
  output logic [63:0]       rsp_iova,
  output logic [63:0]       rsp_paddr,
  output logic [11:0]       rsp_page_mask,
  output logic              rsp_fault,
  output logic [1:0]        rsp_perm
);
  localparam int NREG = 5;
  localparam int RIW  = $clog2(NREG);
  localparam int WW   = CFG_AW - 3;
  localparam logic [WW-1:0] BASE_W = REG_BASE[CFG_AW-1:3];
  localparam int R_WBASE = 0, R_WMASK = 1, R_DIR = 4;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} st_t;
  st_t state;

  logic [63:0] regs_v [NREG];
  wire [WW-1:0] word   = cfg_addr[CFG_AW-1:3];
  wire [WW-1:0] rel    = word - BASE_W;
  wire          in_map = (word >= BASE_W) && (rel < WW'(NREG));

  for (genvar g = 0; g < NREG; g++) begin : gen_reg
    logic [63:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else if (cfg_we && in_map && rel == WW'(g)) begin
        if (cfg_wide)         q <= cfg_wdata;
        else if (cfg_addr[2]) q[63:32] <= cfg_wdata[31:0];
        else                  q[31:0]  <= cfg_wdata[31:0];
      end
    end
    assign regs_v[g] = q;
  end

  wire [63:0] sel_q = in_map ? regs_v[rel[RIW-1:0]] : 64'h0;
  assign cfg_rdata = cfg_wide ? sel_q
                   : {32'h0, cfg_addr[2] ? sel_q[63:32] : sel_q[31:0]};

  wire [63:0] page     = {req_addr[63:12], 12'h0};
  wire        win_en   = regs_v[R_WBASE][0];
  wire [63:0] win_base = {regs_v[R_WBASE][63:1], 1'b0};
  wire        hit      = win_en && ((page & regs_v[R_WMASK]) == win_base);
  wire [63:0] byp_addr = (page <= 64'hFFFF_FFFF) ? page + LOW_OFFSET : page;
  wire [63:0] fetch_at = regs_v[R_DIR] + {9'h0, req_addr[63:12], 3'b000};

  logic [63:0] fetch_q;
  assign req_busy      = (state != S_IDLE);
  assign mem_req_valid = (state == S_ISSUE);
  assign mem_req_addr  = fetch_q;
  assign rsp_page_mask = 12'hfff;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      fetch_q   <= '0;
      rsp_valid <= 1'b0;
      rsp_iova  <= '0;
      rsp_paddr <= '0;
      rsp_fault <= 1'b0;
      rsp_perm  <= 2'b00;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          rsp_iova <= page;
          if (hit) begin
            fetch_q <= fetch_at;
            state   <= S_ISSUE;
          end else begin
            rsp_valid <= 1'b1;
            rsp_paddr <= byp_addr;
            rsp_fault <= 1'b0;
            rsp_perm  <= 2'b11;
          end
        end
        S_ISSUE: state <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          rsp_valid <= 1'b1;
          state     <= S_IDLE;
          if (mem_rsp_data[63]) begin
            rsp_paddr <= {1'b0, mem_rsp_data[62:12], 12'h0};
            rsp_fault <= 1'b0;
            rsp_perm  <= 2'b11;
          end else begin
            rsp_paddr <= '0;
            rsp_fault <= 1'b1;
            rsp_perm  <= 2'b00;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/iommu_xlate_chk.sv
module iommu_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_busy,
  input logic        mem_req_valid,
  input logic        rsp_valid,
  input logic [63:0] rsp_iova,
  input logic [63:0] rsp_paddr,
  input logic        rsp_fault,
  input logic [1:0]  rsp_perm
);
  p_fetch_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);
  p_fetch_while_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> req_busy);
  p_idle_at_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_busy);
  p_fault_noperm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_perm == 2'b00));
  p_grant_rw_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_perm == 2'b11 && rsp_paddr[11:0] == 12'h0));
  p_iova_page_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_iova[11:0] == 12'h0));
endmodule

bind iommu_xlate iommu_xlate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_busy(req_busy), .mem_req_valid(mem_req_valid),
  .rsp_valid(rsp_valid), .rsp_iova(rsp_iova), .rsp_paddr(rsp_paddr),
  .rsp_fault(rsp_fault), .rsp_perm(rsp_perm)
);

// File: tb/iommu_xlate_bench.sv
`timescale 1ns/1ps
module iommu_xlate_bench;
  localparam logic [17:0] RB = 18'h20300;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_wide = 0;
  logic [17:0] cfg_addr = '0;
  logic [63:0] cfg_wdata = '0, cfg_rdata;
  logic req_valid = 0, req_busy;
  logic [63:0] req_addr = '0;
  logic mem_req_valid, mem_rsp_valid = 0;
  logic [63:0] mem_req_addr, mem_rsp_data = '0;
  logic rsp_valid, rsp_fault;
  logic [63:0] rsp_iova, rsp_paddr;
  logic [11:0] rsp_page_mask;
  logic [1:0] rsp_perm;

  int checks = 0, fails = 0, mem_reqs = 0;
  logic [63:0] mem_entry = '0, last_fetch = '0;

  always #2.5 clk = ~clk;

  iommu_xlate u_iommu_xlate (.*);

  initial forever begin
    @(negedge clk);
    if (mem_req_valid) begin
      mem_reqs++;
      last_fetch = mem_req_addr;
      repeat (2) @(negedge clk);
      mem_rsp_valid = 1; mem_rsp_data = mem_entry;
      @(negedge clk);
      mem_rsp_valid = 0;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [17:0] a, input logic [63:0] d, input bit w);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d; cfg_wide = w;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic cfg_rd(input logic [17:0] a, input bit w, output logic [63:0] d);
    @(negedge clk); cfg_addr = a; cfg_wide = w;
    #1 d = cfg_rdata;
  endtask

  logic [63:0] g_paddr, g_iova;
  logic g_fault; logic [1:0] g_perm; logic [11:0] g_mask;

  task automatic send(input logic [63:0] a, output int lat);
    @(negedge clk); req_valid = 1; req_addr = a;
    lat = 0;
    for (int k = 1; k <= 30; k++) begin
      @(negedge clk);
      if (k == 1) req_valid = 0;
      if (rsp_valid) begin
        lat = k; g_paddr = rsp_paddr; g_iova = rsp_iova;
        g_fault = rsp_fault; g_perm = rsp_perm; g_mask = rsp_page_mask;
        break;
      end
    end
  endtask

  task automatic t_reset;
    logic [63:0] d;
    check(!req_busy && !rsp_valid && !mem_req_valid, "R1 idle outputs", {req_busy, rsp_valid, mem_req_valid}, 0);
    for (int i = 0; i < 5; i++) begin
      cfg_rd(RB + 18'(i * 8), 1, d);
      check(d == 0, "R1 register reset", d, 0);
    end
  endtask

  task automatic t_regs;
    logic [63:0] d;
    cfg_wr(RB + 18'h20, 64'h1111_2222_3333_4000, 1);
    cfg_wr(RB + 18'h24, 64'hFFFF_0000_AAAA_BBBB, 0);
    cfg_rd(RB + 18'h20, 1, d);
    check(d == 64'hAAAA_BBBB_3333_4000, "R2 upper half merge", d, 64'hAAAA_BBBB_3333_4000);
    cfg_wr(RB + 18'h20, 64'h0000_0000_5555_6000, 0);
    cfg_rd(RB + 18'h20, 0, d);
    check(d == 64'h5555_6000, "R2 lower half read", d, 64'h5555_6000);
    cfg_rd(RB + 18'h24, 0, d);
    check(d == 64'hAAAA_BBBB, "R2 upper half read", d, 64'hAAAA_BBBB);
    cfg_wr(RB + 18'h10, 64'h0123_4567_89AB_CDEF, 1);
    cfg_wr(RB + 18'h18, 64'hFEDC_BA98_7654_3210, 1);
    cfg_rd(RB + 18'h10, 1, d);
    check(d == 64'h0123_4567_89AB_CDEF, "R3 purge slot", d, 64'h0123_4567_89AB_CDEF);
    cfg_rd(RB + 18'h18, 1, d);
    check(d == 64'hFEDC_BA98_7654_3210, "R3 config slot", d, 64'hFEDC_BA98_7654_3210);
    cfg_wr(RB + 18'h28, 64'hDEAD_BEEF_DEAD_BEEF, 1);
    cfg_rd(RB + 18'h28, 1, d);
    check(d == 0, "R3 unmapped slot", d, 0);
    cfg_rd(RB + 18'h20, 1, d);
    check(d == 64'hAAAA_BBBB_5555_6000, "R3 neighbour untouched", d, 64'hAAAA_BBBB_5555_6000);
  endtask

  task automatic t_disabled;
    int lat, n0;
    cfg_wr(RB + 18'h00, 64'h8000_0000, 1);
    cfg_wr(RB + 18'h08, 64'hFFFF_FFFF_F000_0000, 1);
    n0 = mem_reqs;
    send(64'h8000_1234, lat);
    check(lat == 1, "R4 bypass latency", 64'(lat), 1);
    check(mem_reqs == n0, "R4 no fetch", 64'(mem_reqs - n0), 0);
    check(g_paddr == 64'h8000_1000 && g_perm == 2'b11 && !g_fault, "R4 bypass result", g_paddr, 64'h8000_1000);
    check(g_iova == 64'h8000_1000 && g_mask == 12'hfff, "R9 iova and mask", g_iova, 64'h8000_1000);
  endtask

  task automatic t_translate;
    int lat, n0;
    logic [63:0] a, expf;
    cfg_wr(RB + 18'h00, 64'h8000_0001, 1);
    cfg_wr(RB + 18'h20, 64'h0010_0000, 1);
    a = 64'h8123_4567;
    expf = 64'h0010_0000 + ((a >> 12) << 3);
    mem_entry = 64'h8000_00AB_CDEF_1FFF;
    n0 = mem_reqs;
    send(a, lat);
    check(mem_reqs == n0 + 1, "R6 one fetch", 64'(mem_reqs - n0), 1);
    check(last_fetch == expf, "R6 fetch address", last_fetch, expf);
    check(lat == 4, "R7 translated latency", 64'(lat), 4);
    check(g_paddr == 64'h0000_00AB_CDEF_1000 && !g_fault && g_perm == 2'b11, "R7 valid entry", g_paddr, 64'h0000_00AB_CDEF_1000);
    mem_entry = 64'h0000_00AB_CDEF_1000;
    send(a, lat);
    check(g_fault && g_perm == 2'b00, "R8 invalid entry", {g_fault, g_perm}, 3'b100);
  endtask

  task automatic t_window;
    int lat, n0;
    n0 = mem_reqs;
    send(64'h9000_0000, lat);
    check(lat == 1 && mem_reqs == n0 && g_paddr == 64'h9000_0000, "R5 outside window", g_paddr, 64'h9000_0000);
    send(64'h0000_0012_3456_7ABC, lat);
    check(g_paddr == 64'h0000_0012_3456_7000 && mem_reqs == n0, "R9 high pass-through", g_paddr, 64'h0000_0012_3456_7000);
  endtask

  task automatic t_busy;
    int nrsp = 0, n0;
    mem_entry = 64'h8000_0000_0077_7000;
    n0 = mem_reqs;
    @(negedge clk); req_valid = 1; req_addr = 64'h8000_5000;
    @(negedge clk);
    check(req_busy == 1, "R10 busy after accept", 64'(req_busy), 1);
    req_addr = 64'h9000_0000;
    @(negedge clk); req_valid = 0;
    for (int k = 0; k < 12; k++) begin
      if (rsp_valid) begin
        nrsp++;
        check(rsp_paddr == 64'h0077_7000, "R10 result of first request", rsp_paddr, 64'h0077_7000);
      end
      @(negedge clk);
    end
    check(nrsp == 1 && mem_reqs == n0 + 1, "R10 stalled request dropped", 64'(nrsp), 1);
    check(!req_busy, "R10 busy released", 64'(req_busy), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_regs;
    t_disabled;
    t_translate;
    t_window;
    t_busy;
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule